// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block is a small set-associative store for the fetch stage. It keeps the first two instructions found at the destination of branches that were recently taken. The fetch stage presents the fetch address of a branch. If that address is held in the store, the two target instructions come back one clock later. This is one cycle sooner than the instruction cache could supply them, so fetch can redirect without a bubble.

The store has 16 sets of 4 ways. Each way holds a valid bit, an address tag and a 64-bit payload made of two 32-bit instructions. Branch resolution fills the store through an allocate port that carries the branch address and the instruction pair:

- An allocation whose tag is already present in the set rewrites that way.
- Otherwise it fills the lowest empty way.
- When the set is full, it evicts the way chosen by a three-bit tree pseudo-LRU.

A single flush input empties the whole store in one clock.

Top module: `brtgt_cache`

## Requirements
- R1: While reset is asserted and after it is released, every way is invalid and `out_hit` is 0.
- R2: A lookup is registered. One clock after `lk_valid` is high, `out_hit` is 1 only if a valid way in the indexed set holds the lookup tag. When it is 1, `out_insn0` and `out_insn1` carry that way's first and second target instruction. A cycle without `lk_valid` gives `out_hit` = 0 in the following clock.
- R3: Whenever `out_hit` is 0, `out_insn0` and `out_insn1` are both 0.
- R4: The set index is address bits [5:2] and the tag is bits [31:6]. Bits [1:0] of both addresses have no effect on indexing, matching or the stored data.
- R5: An allocation (`al_valid` high, `flush_all` low) makes its way valid with the given tag and payload. A lookup presented in the same cycle sees the contents as they were before the write. Lookups from the next cycle on see the new entry.
- R6: An allocation whose tag matches a valid way of its set rewrites that way's payload. A set never holds two valid ways with the same tag.
- R7: An allocation with no matching tag fills the lowest-numbered invalid way of the set. If all four ways are valid, it replaces the pseudo-LRU victim. The victim is read from tree bits b0 (root), b1 (ways 0/1) and b2 (ways 2/3): b0=0 selects way b1, and b0=1 selects way 2+b2. The bits used are those held at the start of the cycle.
- R8: A lookup hit or an allocation on way w sets b0 = NOT w[1]. It then sets b1 = NOT w[0] when w<2, or b2 = NOT w[0] otherwise. If a lookup hit and an allocation touch the same set in one cycle, the lookup update is applied first and the allocation update second.
- R9: `flush_all` clears every valid bit and every pseudo-LRU bit in one clock. A lookup in the same cycle reports a miss, and an allocation in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Branch fetch address for lookup |
| al_valid | input | 1 | Allocate/update request |
| al_addr | input | 32 | Branch address being allocated |
| al_insn0 | input | 32 | First target instruction |
| al_insn1 | input | 32 | Second target instruction |
| flush_all | input | 1 | Invalidate every entry |
| out_hit | output | 1 | Registered lookup hit |
| out_insn0 | output | 32 | First target instruction on a hit, else 0 |
| out_insn1 | output | 32 | Second target instruction on a hit, else 0 |

## Verification
The assertions assume the allocate port is the only source of new entries. Tag uniqueness within a set then holds only because the allocate path checks for an existing match. The assertions also assume that address and data inputs are known whenever their valid is high.

The stimulus always drives fully defined values on every input. It draws tags from a pool of six and indexes mostly from three sets, so that hits, same-set lookup/allocate collisions and full-set evictions occur often. It raises flush rarely, so sets can fill between flushes.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);
    localparam int LRU_W = WAYS - 1;

    // Tree update after touching way w: point the tree away from w.
    function automatic logic [LRU_W-1:0] plru_touch(input logic [LRU_W-1:0] bits,
                                                     input logic [WAY_W-1:0] w);
        logic [LRU_W-1:0] r;
        r    = bits;
        r[0] = ~w[1];
        if (!w[1]) r[1] = ~w[0];
        else       r[2] = ~w[0];
        return r;
    endfunction

    // Way the tree points to.
    function automatic logic [WAY_W-1:0] plru_pick(input logic [LRU_W-1:0] bits);
        return bits[0] ? {1'b1, bits[2]} : {1'b0, bits[1]};
    endfunction

endpackage

// File: rtl/brtgt_match.sv
module brtgt_match
    import brtgt_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic [WAYS-1:0]            vld_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]           key_i,
    output logic [WAYS-1:0]            match_o,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match_o[g] = vld_i[g] && (tags_i[g] == key_i);
    end

    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_o[w]) way_o = WAY_W'(w);
        end
    end

    assign hit_o = |match_o;

endmodule

// File: rtl/brtgt_repl.sv
module brtgt_repl
    import brtgt_pkg::*;
(
    input  logic [WAYS-1:0]  vld_i,
    input  logic [LRU_W-1:0] lru_i,
    output logic [WAY_W-1:0] victim_o
);

    logic [WAY_W-1:0] free_way;

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_i[w]) free_way = WAY_W'(w);
        end
    end

    assign victim_o = (&vld_i) ? plru_pick(lru_i) : free_way;

endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache
    import brtgt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 16,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              al_valid,
    input  logic [ADDR_W-1:0] al_addr,
    input  logic [INSN_W-1:0] al_insn0,
    input  logic [INSN_W-1:0] al_insn1,
    input  logic              flush_all,
    output logic              out_hit,
    output logic [INSN_W-1:0] out_insn0,
    output logic [INSN_W-1:0] out_insn1
);

    localparam int IDX_W = $clog2(SETS);
    localparam int OFS_W = 2;
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam int PAY_W = 2 * INSN_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][PAY_W-1:0] pay;
        logic [SETS-1:0][LRU_W-1:0]           lru;
        logic                                 hit;
        logic [PAY_W-1:0]                     dout;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] lk_idx, al_idx;
    logic [TAG_W-1:0] lk_tag, al_tag;
    logic [WAYS-1:0]  lk_match, al_match;
    logic             lk_hit, al_hit;
    logic [WAY_W-1:0] lk_way, al_mway, al_victim, al_way;

    assign lk_idx = lk_addr[OFS_W +: IDX_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign al_idx = al_addr[OFS_W +: IDX_W];
    assign al_tag = al_addr[ADDR_W-1 -: TAG_W];

    brtgt_match #(.TAG_W(TAG_W)) i_lk_match (
        .vld_i   (st_q.vld[lk_idx]),
        .tags_i  (st_q.tag[lk_idx]),
        .key_i   (lk_tag),
        .match_o (lk_match),
        .hit_o   (lk_hit),
        .way_o   (lk_way)
    );

    brtgt_match #(.TAG_W(TAG_W)) i_al_match (
        .vld_i   (st_q.vld[al_idx]),
        .tags_i  (st_q.tag[al_idx]),
        .key_i   (al_tag),
        .match_o (al_match),
        .hit_o   (al_hit),
        .way_o   (al_mway)
    );

    brtgt_repl i_repl (
        .vld_i    (st_q.vld[al_idx]),
        .lru_i    (st_q.lru[al_idx]),
        .victim_o (al_victim)
    );

    assign al_way = al_hit ? al_mway : al_victim;

    always_comb begin
        st_d      = st_q;
        st_d.hit  = 1'b0;
        st_d.dout = '0;
        if (flush_all) begin
            st_d.vld = '0;
            st_d.lru = '0;
        end else begin
            if (lk_valid && lk_hit) begin
                st_d.hit         = 1'b1;
                st_d.dout        = st_q.pay[lk_idx][lk_way];
                st_d.lru[lk_idx] = plru_touch(st_q.lru[lk_idx], lk_way);
            end
            if (al_valid) begin
                st_d.vld[al_idx][al_way] = 1'b1;
                st_d.tag[al_idx][al_way] = al_tag;
                st_d.pay[al_idx][al_way] = {al_insn1, al_insn0};
                st_d.lru[al_idx]         = plru_touch(st_d.lru[al_idx], al_way);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_hit   = st_q.hit;
    assign out_insn0 = st_q.dout[INSN_W-1:0];
    assign out_insn1 = st_q.dout[PAY_W-1:INSN_W];

    p_lk_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(lk_match));
    p_al_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
        al_valid |-> $onehot0(al_match));
    p_idle_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !out_hit);
    p_quiet_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit |-> (out_insn0 == '0 && out_insn1 == '0));
    p_flush_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !out_hit);
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (st_q.vld == '0));
    p_alloc_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (al_valid && !flush_all) |=> (st_q.vld[$past(al_idx)] != '0));

endmodule

// File: tb/test_brtgt_cache.sv
module test_brtgt_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, al_valid = 1'b0, flush_all = 1'b0;
    logic [31:0] lk_addr = '0, al_addr = '0, al_insn0 = '0, al_insn1 = '0;
    logic        out_hit;
    logic [31:0] out_insn0, out_insn1;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    bit          m_valid[16][4];
    logic [25:0] m_tag[16][4];
    logic [31:0] m_i0[16][4];
    logic [31:0] m_i1[16][4];
    logic [2:0]  m_lru[16];

    always #5 clk = ~clk;

    brtgt_cache i_brtgt_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .al_valid(al_valid), .al_addr(al_addr),
        .al_insn0(al_insn0), .al_insn1(al_insn1),
        .flush_all(flush_all),
        .out_hit(out_hit), .out_insn0(out_insn0), .out_insn1(out_insn1)
    );

    function automatic logic [2:0] ref_touch(input logic [2:0] b, input int w);
        logic [2:0] r = b;
        r[0] = (w < 2);
        if (w < 2) r[1] = (w == 0);
        else       r[2] = (w == 2);
        return r;
    endfunction

    function automatic int ref_victim(input int set, input logic [2:0] b);
        for (int w = 0; w < 4; w++) if (!m_valid[set][w]) return w;
        if (b[0] == 1'b0) return b[1] ? 1 : 0;
        return b[2] ? 3 : 2;
    endfunction

    function automatic logic [31:0] mk_addr(input int tg, input int ix);
        return {26'(tg), 4'(ix), 2'($urandom)};
    endfunction

    task automatic compare(input bit eh, input logic [31:0] e0, input logic [31:0] e1,
                           input string rq);
        vectors++;
        if (out_hit !== eh || out_insn0 !== e0 || out_insn1 !== e1) begin
            fails++;
            $display("FAIL %s: hit=%0b i0=%h i1=%h expected hit=%0b i0=%h i1=%h",
                     rq, out_hit, out_insn0, out_insn1, eh, e0, e1);
        end
    endtask

    // Drive one cycle at a falling edge, advance the model, check at the next falling edge.
    task automatic step(input bit lk, input logic [31:0] la, input bit al,
                        input logic [31:0] aa, input logic [31:0] d0, input logic [31:0] d1,
                        input bit fl, input string rq);
        int li, ai, lw, aw;
        bit eh;
        logic [31:0] e0, e1;
        logic [2:0]  old_al_lru;
        lk_valid = lk; lk_addr = la; al_valid = al; al_addr = aa;
        al_insn0 = d0; al_insn1 = d1; flush_all = fl;
        li = int'(la[5:2]); ai = int'(aa[5:2]);
        eh = 1'b0; e0 = '0; e1 = '0; lw = 0;
        if (lk && !fl)
            for (int w = 0; w < 4; w++)
                if (m_valid[li][w] && m_tag[li][w] == la[31:6]) begin
                    eh = 1'b1; lw = w; e0 = m_i0[li][w]; e1 = m_i1[li][w];
                end
        if (fl) begin
            for (int s = 0; s < 16; s++) begin
                m_lru[s] = '0;
                for (int w = 0; w < 4; w++) m_valid[s][w] = 1'b0;
            end
        end else begin
            old_al_lru = m_lru[ai];
            if (eh) m_lru[li] = ref_touch(m_lru[li], lw);
            if (al) begin
                aw = -1;
                for (int w = 0; w < 4; w++)
                    if (m_valid[ai][w] && m_tag[ai][w] == aa[31:6]) aw = w;
                if (aw < 0) aw = ref_victim(ai, old_al_lru);
                m_valid[ai][aw] = 1'b1; m_tag[ai][aw] = aa[31:6];
                m_i0[ai][aw] = d0; m_i1[ai][aw] = d1;
                m_lru[ai] = ref_touch(m_lru[ai], aw);
            end
        end
        @(negedge clk);
        compare(eh, e0, e1, rq);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < 16; s++) begin
            m_lru[s] = '0;
            for (int w = 0; w < 4; w++) m_valid[s][w] = 1'b0;
        end
        lk_valid = 1'b1; lk_addr = 32'h40;
        repeat (3) @(negedge clk);
        compare(1'b0, '0, '0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(1'b0, '0, '0, "R1 after reset");
        for (int i = 0; i < 4; i++) step(1, mk_addr(i, i), 0, 0, 0, 0, 0, "R1 empty lookup");

        // Fill one set, check it, then evict through the tree.
        for (int t = 1; t <= 4; t++)
            step(0, 0, 1, mk_addr(t, 5), 32'h1000 + t, 32'h2000 + t, 0, "R7 fill");
        for (int t = 1; t <= 4; t++) step(1, mk_addr(t, 5), 0, 0, 0, 0, 0, "R5 fill visible");
        step(1, mk_addr(3, 5), 1, mk_addr(9, 5), 32'hAAAA0001, 32'hBBBB0001, 0, "R8 same-set order");
        for (int t = 1; t <= 4; t++) step(1, mk_addr(t, 5), 0, 0, 0, 0, 0, "R7 eviction");
        step(1, mk_addr(9, 5), 0, 0, 0, 0, 0, "R5 new entry");
        step(1, mk_addr(9, 6), 0, 0, 0, 0, 0, "R4 other index misses");
        step(1, {26'd9, 4'd5, 2'b11}, 0, 0, 0, 0, 0, "R4 low bits ignored");
        // Rewrite an existing tag; lookup in the same cycle sees old data.
        step(1, mk_addr(9, 5), 1, mk_addr(9, 5), 32'hCAFE0000, 32'hF00D0000, 0, "R5 same-cycle old");
        step(1, mk_addr(9, 5), 0, 0, 0, 0, 0, "R6 overwrite");
        step(0, mk_addr(9, 5), 0, 0, 0, 0, 0, "R2 idle miss");
        step(1, mk_addr(2, 5), 1, mk_addr(7, 5), 32'h1, 32'h2, 1, "R9 flush with lookup");
        step(1, mk_addr(7, 5), 0, 0, 0, 0, 0, "R9 alloc dropped");
        step(1, mk_addr(4, 5), 0, 0, 0, 0, 0, "R9 cleared");

        for (int n = 0; n < 4000; n++) begin
            bit lk, al, fl;
            lk = ($urandom_range(0, 9) < 7);
            al = ($urandom_range(0, 9) < 4);
            fl = ($urandom_range(0, 199) == 0);
            step(lk, mk_addr($urandom_range(0, 5), ($urandom_range(0, 7) == 0) ?
                             $urandom_range(0, 15) : $urandom_range(0, 2)),
                 al, mk_addr($urandom_range(0, 5), $urandom_range(0, 2)),
                 $urandom, $urandom, fl, "R2 R3 R6 R8 random");
        end
        done = 1'b1;
        finish_run();
    end

endmodule